// File: doc/BRIEF.md
# Bus-Programmable Fan Speed PWM

This block drives a fan's switching transistor with a fixed-frequency pulse train whose on-time is set by software over an AXI4-Lite slave port. The slave port exposes four 32-bit storage words. The word at byte offset 0x0 sets the fan speed. The remaining three words are general storage with no effect on the output.

The pulse generator counts continuously through 256 clock cycles per period. With a 25 MHz clock this gives roughly 97.6 kHz, which is well above hearing range. The output is registered. In each period it stays high for as many clocks as the low byte of the speed word. The upper 24 bits of that word are kept and read back, but they never reach the generator. The generator picks up a new on-time only when its count wraps to zero, so a speed change always starts on a clean period boundary.

A bus master writes a value from 0 (fan stopped) to 255 (fastest) into offset 0x0. The master may read any word back at any time.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: During and after reset, pwm_out is low, BVALID and RVALID are low, AWREADY is high, and all four storage words read as zero.
- R2: Byte address bits [3:2] select one of four independent 32-bit words, at offsets 0x0, 0x4, 0x8 and 0xC. Each word reads back exactly what was last stored in it.
- R3: A write updates only the byte lanes whose strobe bit is set. Strobe bit i covers data bits [8i+7:8i], and unselected lanes keep their old contents.
- R4: The write address and write data may arrive in the same cycle or in either order, with gaps between them. Each write produces exactly one response, and that response has BRESP = 2'b00.
- R5: Once raised, BVALID stays high until BREADY is seen. Once raised, RVALID stays high with RDATA unchanged until RREADY is seen. RRESP is always 2'b00.
- R6: The internal count steps by one on every clock and wraps from 255 to 0. Successive rising edges of pwm_out are therefore 256 clocks apart.
- R7: In each period pwm_out is high for exactly D consecutive clocks and low for the rest, where D is bits [7:0] of the word at offset 0x0. Bits [31:8] of that word have no effect on the output but read back unchanged.
- R8: With D = 0, pwm_out never goes high. With D = 255, pwm_out is high for 255 clocks and low for 1 clock in each period.
- R9: A new D value is adopted only at the count wrap. A period that is already running keeps its old pulse width, and the following period uses the new width.
- R10: Writes to offsets 0x4, 0x8 and 0xC do not change the pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and generator |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | 4 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte-lane enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 4 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| pwm_out | output | 1 | Pulse output to the fan switch |

## Verification
The pulse generator is tried with several on-time values. A mid value shows that the width tracks the byte exactly. A word with non-zero upper bits shows the truncation. The values 0 and 255 separate "never on" from "one low clock per period". Changing the on-time while a pulse is in progress, first to a larger value and then to a smaller one, shows that the running period keeps its width and the change lands at the wrap. The bus side is driven with address and data together, address first and data first, and with delayed BREADY and RREADY. These patterns separate correct pairing and holding from dropped or duplicated responses.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    typedef logic [1:0] axi_resp_t;
    localparam axi_resp_t RESP_OKAY = 2'b00;
    localparam int        LANE_W    = 8;
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DUTY_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        awaddr,
    input  logic                     awvalid,
    output logic                     awready,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/LANE_W-1:0] wstrb,
    input  logic                     wvalid,
    output logic                     wready,
    output axi_resp_t                bresp,
    output logic                     bvalid,
    input  logic                     bready,
    input  logic [ADDR_W-1:0]        araddr,
    input  logic                     arvalid,
    output logic                     arready,
    output logic [DATA_W-1:0]        rdata,
    output axi_resp_t                rresp,
    output logic                     rvalid,
    input  logic                     rready,
    output logic [DUTY_W-1:0]        duty_word
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int STRB_W   = DATA_W / LANE_W;

    typedef struct packed {
        logic                               aw_held;
        logic [ADDR_W-1:0]                  aw_addr;
        logic                               w_held;
        logic [DATA_W-1:0]                  w_data;
        logic [STRB_W-1:0]                  w_strb;
        logic                               b_valid;
        logic                               r_valid;
        logic [DATA_W-1:0]                  r_data;
        logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
    } bank_t;

    bank_t q, d;

    logic              aw_fire, w_fire, ar_fire;
    logic              have_aw, have_w;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] eff_data;
    logic [STRB_W-1:0] eff_strb;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] cur_word, merged;

    assign awready = !q.aw_held && !q.b_valid;
    assign wready  = !q.w_held && !q.b_valid;
    assign arready = !q.r_valid;

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign ar_fire = arvalid && arready;

    assign have_aw  = q.aw_held || aw_fire;
    assign have_w   = q.w_held || w_fire;
    assign eff_addr = q.aw_held ? q.aw_addr : awaddr;
    assign eff_data = q.w_held ? q.w_data : wdata;
    assign eff_strb = q.w_held ? q.w_strb : wstrb;
    assign wr_idx   = eff_addr[ADDR_W-1:2];
    assign rd_idx   = araddr[ADDR_W-1:2];
    assign cur_word = q.regs[wr_idx];

    for (genvar ln = 0; ln < STRB_W; ln++) begin : g_lane
        assign merged[ln*LANE_W +: LANE_W] = eff_strb[ln]
            ? eff_data[ln*LANE_W +: LANE_W]
            : cur_word[ln*LANE_W +: LANE_W];
    end

    always_comb begin
        d = q;
        if (q.b_valid && bready) d.b_valid = 1'b0;
        if (q.r_valid && rready) d.r_valid = 1'b0;

        if (have_aw && have_w) begin
            d.regs[wr_idx] = merged;
            d.b_valid      = 1'b1;
            d.aw_held      = 1'b0;
            d.w_held       = 1'b0;
        end else begin
            if (aw_fire) begin
                d.aw_held = 1'b1;
                d.aw_addr = awaddr;
            end
            if (w_fire) begin
                d.w_held = 1'b1;
                d.w_data = wdata;
                d.w_strb = wstrb;
            end
        end

        if (ar_fire) begin
            d.r_valid = 1'b1;
            d.r_data  = q.regs[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign bvalid    = q.b_valid;
    assign bresp     = RESP_OKAY;
    assign rvalid    = q.r_valid;
    assign rdata     = q.r_data;
    assign rresp     = RESP_OKAY;
    assign duty_word = q.regs[0][DUTY_W-1:0];
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        logic             out;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == CNT_MAX) begin
            d.cnt  = '0;
            d.duty = duty_in;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        d.out = (q.cnt < q.duty);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign cnt_o  = q.cnt;
    assign duty_o = q.duty;
    assign pwm_o  = q.out;
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PWM_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        s_awaddr,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [DATA_W-1:0]        s_wdata,
    input  logic [DATA_W/LANE_W-1:0] s_wstrb,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    output logic [1:0]               s_bresp,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic [ADDR_W-1:0]        s_araddr,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    output logic [DATA_W-1:0]        s_rdata,
    output logic [1:0]               s_rresp,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    output logic                     pwm_out
);
    logic [PWM_W-1:0] duty_word;
    logic [PWM_W-1:0] pwm_cnt;
    logic [PWM_W-1:0] pwm_duty;

    fan_pwm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DUTY_W (PWM_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .awaddr    (s_awaddr),
        .awvalid   (s_awvalid),
        .awready   (s_awready),
        .wdata     (s_wdata),
        .wstrb     (s_wstrb),
        .wvalid    (s_wvalid),
        .wready    (s_wready),
        .bresp     (s_bresp),
        .bvalid    (s_bvalid),
        .bready    (s_bready),
        .araddr    (s_araddr),
        .arvalid   (s_arvalid),
        .arready   (s_arready),
        .rdata     (s_rdata),
        .rresp     (s_rresp),
        .rvalid    (s_rvalid),
        .rready    (s_rready),
        .duty_word (duty_word)
    );

    fan_pwm_gen #(
        .CNT_W (PWM_W)
    ) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .duty_in (duty_word),
        .cnt_o   (pwm_cnt),
        .duty_o  (pwm_duty),
        .pwm_o   (pwm_out)
    );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int PWM_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [1:0]        rresp,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm_out,
    input logic [PWM_W-1:0]  cnt,
    input logic [PWM_W-1:0]  duty
);
    localparam logic [PWM_W-1:0] CNT_TOP = {PWM_W{1'b1}};

    a_r5_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    a_r5_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

    a_r4_bresp_okay: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> bresp == 2'b00);

    a_r5_rresp_okay: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rresp == 2'b00);

    a_r6_cnt_wrap: assert property (@(posedge clk) disable iff (rst)
        cnt == CNT_TOP |=> cnt == '0);

    a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
        cnt != CNT_TOP |=> cnt == PWM_W'($past(cnt) + 1'b1));

    a_r9_duty_held: assert property (@(posedge clk) disable iff (rst)
        cnt != CNT_TOP |=> $stable(duty));

    a_r8_zero_low: assert property (@(posedge clk) disable iff (rst)
        duty == '0 |=> !pwm_out);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(
    .DATA_W (DATA_W),
    .PWM_W  (PWM_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .bresp   (s_bresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rresp   (s_rresp),
    .rdata   (s_rdata),
    .pwm_out (pwm_out),
    .cnt     (pwm_cnt),
    .duty    (pwm_duty)
);

// File: tb/fan_pwm_ctrl_tb.sv
module fan_pwm_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [3:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic        pwm_out;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_pwm_ctrl u_dut (
        .clk(clk), .rst(rst),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_aw(input logic [3:0] a);
        s_awaddr  = a;
        s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] dt, input logic [3:0] st);
        s_wdata  = dt;
        s_wstrb  = st;
        s_wvalid = 1'b1;
        while (!s_wready) @(negedge clk);
        @(negedge clk);
        s_wvalid = 1'b0;
    endtask

    // mode 0: together, 1: address first, 2: data first
    task automatic axi_write(input logic [3:0] a, input logic [31:0] dt, input logic [3:0] st,
                             input int mode, input int bdelay);
        case (mode)
            1: begin send_aw(a); repeat (3) @(negedge clk); send_w(dt, st); end
            2: begin send_w(dt, st); repeat (2) @(negedge clk); send_aw(a); end
            default: fork send_aw(a); send_w(dt, st); join
        endcase
        while (!s_bvalid) @(negedge clk);
        check(s_bresp == 2'b00, "R4 bresp", 32'(s_bresp), 0);
        for (int i = 0; i < bdelay; i++) begin
            @(negedge clk);
            check(s_bvalid, "R5 bvalid held", 32'(s_bvalid), 1);
        end
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        check(!s_bvalid, "R4 single response", 32'(s_bvalid), 0);
    endtask

    task automatic axi_read(input logic [3:0] a, input int rdelay, output logic [31:0] dt);
        s_araddr  = a;
        s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        dt = s_rdata;
        check(s_rresp == 2'b00, "R5 rresp", 32'(s_rresp), 0);
        for (int i = 0; i < rdelay; i++) begin
            @(negedge clk);
            check(s_rvalid && s_rdata == dt, "R5 rdata held", s_rdata, dt);
        end
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic settle();
        repeat (260) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pwm_out;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic count_high(output int w);
        w = 1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!pwm_out) break;
            w++;
        end
    endtask

    task automatic pulse_width(output int w);
        wait_rise();
        count_high(w);
    endtask

    task automatic period_len(output int p);
        logic prev;
        wait_rise();
        prev = 1'b1;
        p = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            p++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        check(!pwm_out, "R1 pwm low", 32'(pwm_out), 0);
        check(!s_bvalid && !s_rvalid, "R1 valids low", {s_bvalid, s_rvalid}, 0);
        check(s_awready, "R1 awready", 32'(s_awready), 1);
        for (int k = 0; k < 4; k++) begin
            axi_read(4'(k * 4), 0, rd);
            check(rd == 0, "R1 reg reset", rd, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] rd;
        for (int k = 0; k < 4; k++) axi_write(4'(k * 4), 32'h1111_0000 * (k + 1) + 32'(k), 4'hF, 0, 0);
        for (int k = 0; k < 4; k++) begin
            axi_read(4'(k * 4), 0, rd);
            check(rd == 32'h1111_0000 * (k + 1) + 32'(k), "R2 readback", rd, 32'h1111_0000 * (k + 1) + 32'(k));
        end
    endtask

    task automatic t_order();
        logic [31:0] rd;
        axi_write(4'h4, 32'hCAFE_0001, 4'hF, 1, 0);
        axi_read(4'h4, 0, rd);
        check(rd == 32'hCAFE_0001, "R4 address first", rd, 32'hCAFE_0001);
        axi_write(4'h8, 32'hBEEF_0002, 4'hF, 2, 0);
        axi_read(4'h8, 0, rd);
        check(rd == 32'hBEEF_0002, "R4 data first", rd, 32'hBEEF_0002);
        axi_read(4'h4, 0, rd);
        check(rd == 32'hCAFE_0001, "R4 no cross write", rd, 32'hCAFE_0001);
    endtask

    task automatic t_strb();
        logic [31:0] rd;
        axi_write(4'hC, 32'hFFFF_FFFF, 4'hF, 0, 0);
        axi_write(4'hC, 32'h0000_0000, 4'b0101, 0, 0);
        axi_read(4'hC, 0, rd);
        check(rd == 32'hFF00_FF00, "R3 lanes 0,2", rd, 32'hFF00_FF00);
        axi_write(4'hC, 32'h1234_5678, 4'b1000, 0, 0);
        axi_read(4'hC, 0, rd);
        check(rd == 32'h1200_FF00, "R3 lane 3", rd, 32'h1200_FF00);
    endtask

    task automatic t_hold();
        logic [31:0] rd;
        axi_write(4'h8, 32'h0BAD_F00D, 4'hF, 0, 5);
        axi_read(4'h8, 6, rd);
        check(rd == 32'h0BAD_F00D, "R5 held read value", rd, 32'h0BAD_F00D);
    endtask

    task automatic t_duty();
        int w, p;
        axi_write(4'h0, 32'd40, 4'hF, 0, 0);
        settle();
        pulse_width(w);
        check(w == 40, "R7 width 40", w, 40);
        period_len(p);
        check(p == 256, "R6 period", p, 256);
    endtask

    task automatic t_trunc();
        int w;
        logic [31:0] rd;
        axi_write(4'h0, 32'hABCD_1250, 4'hF, 0, 0);
        settle();
        pulse_width(w);
        check(w == 32'h50, "R7 low byte only", w, 32'h50);
        axi_read(4'h0, 0, rd);
        check(rd == 32'hABCD_1250, "R7 upper bits read back", rd, 32'hABCD_1250);
    endtask

    task automatic t_extremes();
        int w, p, highs;
        axi_write(4'h0, 32'd0, 4'hF, 0, 0);
        settle();
        highs = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
        check(highs == 0, "R8 duty 0 never high", highs, 0);
        axi_write(4'h0, 32'd255, 4'hF, 0, 0);
        settle();
        pulse_width(w);
        check(w == 255, "R8 duty 255 width", w, 255);
        period_len(p);
        check(p == 256, "R8 duty 255 period", p, 256);
    endtask

    task automatic t_unused();
        int w;
        axi_write(4'h0, 32'd40, 4'hF, 0, 0);
        axi_write(4'h4, 32'hFFFF_FFFF, 4'hF, 0, 0);
        axi_write(4'h8, 32'h0000_00C8, 4'hF, 1, 0);
        axi_write(4'hC, 32'h0000_0001, 4'hF, 2, 0);
        settle();
        pulse_width(w);
        check(w == 40, "R10 other words ignored", w, 40);
    endtask

    task automatic t_boundary();
        int w1, w2;
        axi_write(4'h0, 32'd10, 4'hF, 0, 0);
        settle();
        wait_rise();
        fork
            count_high(w1);
            axi_write(4'h0, 32'd200, 4'hF, 0, 0);
        join
        check(w1 == 10, "R9 running period keeps width", w1, 10);
        pulse_width(w2);
        check(w2 == 200, "R9 next period grows", w2, 200);
        wait_rise();
        fork
            count_high(w1);
            axi_write(4'h0, 32'd30, 4'hF, 0, 0);
        join
        check(w1 == 200, "R9 running period keeps wide width", w1, 200);
        pulse_width(w2);
        check(w2 == 30, "R9 next period shrinks", w2, 30);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_order();
        t_strb();
        t_hold();
        t_duty();
        t_trunc();
        t_extremes();
        t_unused();
        t_boundary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule